// File: doc/BRIEF.md
# Bulk OUT Endpoint DMA Request Controller

This block sits beside the receive buffer of a USB bulk OUT endpoint and decides when the DMA controller is asked to empty it. The buffer holds one received packet of up to 64 bytes. A small byte counter stands in for the buffer. It is loaded when a packet is accepted, and each read strobe from the DMA engine (or from software) takes one byte off it. Software arms the DMA path with an enable bit and a two-bit request-mode field. Only the demand mode (`2'b10`) produces requests. While the path is armed, the DMA request takes the place of the endpoint's ordinary receive interrupt.

The request is held high for as long as bytes remain, and it drops the cycle after the last byte is read. A packet shorter than 64 bytes ends a transfer. When its last byte is read, the block sets a level short-packet status, pulses the short and endpoint-end interrupts, and clears the enable bit. A terminal-count signal from the DMA controller also clears the enable bit and pulses a DMA-end interrupt, and any remaining bytes stay in the buffer until software re-arms the path. While the short status is still set, a stop output is raised and no request can start, whatever the enable bit holds. Software clears the status by writing one to it.

A three-state machine owns the request:
- **EMPTY**: no bytes are buffered.
- **WAIT**: bytes are buffered but the path is not armed.
- **REQ**: the request is driven.

Its transitions are:
- **load-idle**: EMPTY to WAIT.
- **load-armed**: EMPTY to REQ.
- **arm**: WAIT to REQ. This happens on an enable or mode write, or when the short status is cleared.
- **disarm**: REQ to WAIT. This happens on terminal count or a software write.
- **drain**: REQ to EMPTY, and WAIT to EMPTY when the last byte is read.

Top module: `bulk_out_dma_req`

## Requirements
- R1: After reset, the enable bit, mode field, byte count, short status and underflow flag are all zero, and the request, stop and every interrupt output are low.
- R2: `dma_req` is high only while the enable bit is 1, the mode field is `2'b10`, the byte count is nonzero and the short status is clear. It is never high while the enable bit is 0.
- R3: An accepted packet pulses `rx_irq` for one cycle, starting the cycle after `pkt_ok`, unless the path is armed in the `pkt_ok` cycle. Armed means enable 1, mode `2'b10` and short status clear. When the path is armed, `rx_irq` stays low.
- R4: In demand mode, `dma_req` rises the cycle after an accepted packet. It stays high while bytes remain and is low the cycle after the read of the last byte. It rises again after the next accepted packet if the enable bit is still 1.
- R5: If the last byte of a packet of 1 to 63 bytes is read while the request is high, then in the next cycle all of the following hold:
  - `short_irq` and `ep_end_irq` are each high for exactly one cycle;
  - the enable bit is 0;
  - `dma_req` is low;
  - `dma_stop` is high.
  A 64-byte packet produces none of these and leaves the enable bit at 1.
- R6: `dma_tc` high clears the enable bit, drops `dma_req` and pulses `dma_end_irq`, all in the next cycle. The byte count is kept. The request returns the cycle after software writes the enable bit to 1 again.
- R7: `dma_stop` is high exactly while the short status is set, and during that time `dma_req` stays low even with the path enabled. A `short_clr` pulse clears the status. Then `dma_stop` falls and, if bytes are present and the path is enabled, `dma_req` rises in the next cycle.
- R8: With a mode field other than `2'b10`, `dma_req` stays low even with the enable bit at 1 and bytes present. Writing `2'b10` raises the request in the next cycle.
- R9: Each `fifo_rd` while bytes are present lowers `byte_cnt` by one. A `fifo_rd` while the count is 0 leaves the count at 0 and sets `underflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Software write strobe for the enable bit and mode field |
| cfg_en | input | 1 | Enable value written on `cfg_wr` |
| cfg_mode | input | 2 | Request-mode value written on `cfg_wr` (`2'b10` = demand) |
| pkt_ok | input | 1 | One-cycle pulse: a packet was received without error |
| pkt_len | input | 7 | Byte count of the received packet (0 to 64) |
| fifo_rd | input | 1 | Read strobe removing one byte from the buffer |
| dma_tc | input | 1 | Terminal count from the DMA controller |
| short_clr | input | 1 | Write-one-to-clear of the short-packet status |
| dma_req | output | 1 | DMA request |
| rx_irq | output | 1 | Ordinary receive interrupt pulse (DMA path not armed) |
| short_irq | output | 1 | Short-packet interrupt pulse |
| ep_end_irq | output | 1 | Endpoint transfer-end interrupt pulse |
| dma_end_irq | output | 1 | DMA terminal-count interrupt pulse |
| dma_stop | output | 1 | Short status pending; DMA blocked |
| dma_en | output | 1 | Current value of the enable bit |
| byte_cnt | output | 7 | Bytes remaining in the buffer |
| underflow | output | 1 | Sticky: a read hit an empty buffer |

## Verification
The bench compares a full 64-byte packet with short ones. A design that treats 64 bytes as short would clear the enable bit and stall the next packet. A design that forgets the short case would keep requesting past the end of the transfer.

It applies terminal count in the middle of a packet and checks that the remaining bytes survive and the request returns only after the enable bit is rewritten. A wrong design would either drop the data or restart on its own.

It sets the enable bit while a short status is pending, and it uses a non-demand mode. Both check that the request stays low, catching a gate that looks only at the enable bit.

It reads an empty buffer to catch a counter that wraps instead of holding at zero.

// File: rtl/bod_pkg.sv
package bod_pkg;

    // Request-mode code that enables demand-driven requests.
    localparam logic [1:0] MODE_DEMAND = 2'b10;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_REQ   = 2'd2
    } bod_state_e;

endpackage

// File: rtl/bod_fifo_cnt.sv
module bod_fifo_cnt #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_ok,
    input  logic [CW-1:0] pkt_len,
    input  logic          fifo_rd,
    output logic [CW-1:0] cnt_q,
    output logic          cnt_zero_nxt,
    output logic          pkt_accept,
    output logic          last_rd,
    output logic          pkt_short_q,
    output logic          underflow_q
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] len_clip;
    logic [CW-1:0] cnt_nxt;
    logic          rd_ok;
    logic          rd_empty;

    // The buffer holds one packet; a new packet is taken only when it is empty.
    assign pkt_accept = pkt_ok && (cnt_q == '0);
    assign len_clip   = (pkt_len > DEPTH_C) ? DEPTH_C : pkt_len;
    assign rd_ok      = fifo_rd && (cnt_q != '0);
    assign rd_empty   = fifo_rd && (cnt_q == '0);
    assign last_rd    = fifo_rd && (cnt_q == CW'(1));

    always_comb begin
        cnt_nxt = cnt_q;
        if (pkt_accept) begin
            cnt_nxt = len_clip;
        end else if (rd_ok) begin
            cnt_nxt = cnt_q - CW'(1);
        end
    end

    assign cnt_zero_nxt = (cnt_nxt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            pkt_short_q <= 1'b0;
            underflow_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (pkt_accept) begin
                pkt_short_q <= (len_clip < DEPTH_C);
            end
            if (rd_empty) begin
                underflow_q <= 1'b1;
            end
        end
    end

    // R9: a read with bytes present takes exactly one byte off.
    p_rd_decrement_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R9: a read of an empty buffer never wraps the count.
    p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !pkt_ok && cnt_q == '0) |=> (cnt_q == '0 && underflow_q));

    // R9: the underflow flag is sticky.
    p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_q |=> underflow_q);

endmodule

// File: rtl/bod_cfg_reg.sv
module bod_cfg_reg #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              hw_clr,
    output logic              en_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              en_nxt,
    output logic [MODE_W-1:0] mode_nxt
);

    // A hardware clear wins over a software write in the same cycle.
    always_comb begin
        en_nxt   = en_q;
        mode_nxt = mode_q;
        if (cfg_wr) begin
            en_nxt   = cfg_en;
            mode_nxt = cfg_mode;
        end
        if (hw_clr) begin
            en_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= '0;
        end else begin
            en_q   <= en_nxt;
            mode_q <= mode_nxt;
        end
    end

    // R5/R6: an end-of-transfer event always leaves the enable bit cleared.
    p_hwclr_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr |=> !en_q);

endmodule

// File: rtl/bod_status.sv
module bod_status (
    input  logic clk,
    input  logic rst_n,
    input  logic short_done,
    input  logic short_clr,
    input  logic dma_tc,
    input  logic pkt_accept,
    input  logic armed,
    output logic short_sts_q,
    output logic short_nxt,
    output logic rx_irq_q,
    output logic short_irq_q,
    output logic ep_end_irq_q,
    output logic dma_end_irq_q
);

    // Setting the status wins over a clear in the same cycle.
    assign short_nxt = short_done || (short_sts_q && !short_clr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_sts_q   <= 1'b0;
            rx_irq_q      <= 1'b0;
            short_irq_q   <= 1'b0;
            ep_end_irq_q  <= 1'b0;
            dma_end_irq_q <= 1'b0;
        end else begin
            short_sts_q   <= short_nxt;
            rx_irq_q      <= pkt_accept && !armed;
            short_irq_q   <= short_done;
            ep_end_irq_q  <= short_done;
            dma_end_irq_q <= dma_tc;
        end
    end

    // R5: the short interrupt is a single-cycle pulse.
    p_short_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        short_irq_q |=> !short_irq_q);

    // R5: a short interrupt leaves the status set behind it.
    p_short_sets_sts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        short_irq_q |-> short_sts_q);

    // R6: the DMA-end interrupt is a single pulse per terminal-count cycle.
    p_tc_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tc |=> dma_end_irq_q);

endmodule

// File: rtl/bod_req_fsm.sv
module bod_req_fsm
    import bod_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_zero_nxt,
    input  logic              en_nxt,
    input  logic [MODE_W-1:0] mode_nxt,
    input  logic              short_nxt,
    input  logic              last_rd,
    input  logic              pkt_short_q,
    input  logic              en_q,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              cnt_nz,
    input  logic              short_sts_q,
    output bod_state_e        state_q,
    output logic              dma_req,
    output logic              short_done
);

    bod_state_e state_nxt;
    logic       go_nxt;

    assign go_nxt = en_nxt && (mode_nxt == MODE_W'(MODE_DEMAND)) && !short_nxt;

    // Next-state logic.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (!cnt_zero_nxt) begin
                    state_nxt = go_nxt ? ST_REQ : ST_WAIT;   // load-armed / load-idle
                end
            end
            ST_WAIT: begin
                if (cnt_zero_nxt) begin
                    state_nxt = ST_EMPTY;                    // drain
                end else if (go_nxt) begin
                    state_nxt = ST_REQ;                      // arm
                end
            end
            ST_REQ: begin
                if (cnt_zero_nxt) begin
                    state_nxt = ST_EMPTY;                    // drain
                end else if (!go_nxt) begin
                    state_nxt = ST_WAIT;                     // disarm
                end
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Outputs.
    always_comb begin
        dma_req    = (state_q == ST_REQ);
        short_done = (state_q == ST_REQ) && last_rd && pkt_short_q;
    end

    // R2: the request implies an armed path with bytes present.
    p_req_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (en_q && mode_q == MODE_W'(MODE_DEMAND) && cnt_nz));

    // R7: a pending short status blocks the request.
    p_stop_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        short_sts_q |-> !dma_req);

    // R4: the read of the last byte drops the request.
    p_last_read_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && last_rd) |=> !dma_req);

    // R4: an empty buffer never requests.
    p_empty_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_nz |-> !dma_req);

endmodule

// File: rtl/bulk_out_dma_req.sv
module bulk_out_dma_req
    import bod_pkg::*;
#(
    parameter  int DEPTH  = 64,
    parameter  int MODE_W = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              pkt_ok,
    input  logic [CW-1:0]     pkt_len,
    input  logic              fifo_rd,
    input  logic              dma_tc,
    input  logic              short_clr,
    output logic              dma_req,
    output logic              rx_irq,
    output logic              short_irq,
    output logic              ep_end_irq,
    output logic              dma_end_irq,
    output logic              dma_stop,
    output logic              dma_en,
    output logic [CW-1:0]     byte_cnt,
    output logic              underflow
);

    logic [CW-1:0]     cnt_q;
    logic              cnt_zero_nxt;
    logic              pkt_accept;
    logic              last_rd;
    logic              pkt_short_q;
    logic              en_q;
    logic              en_nxt;
    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] mode_nxt;
    logic              short_sts_q;
    logic              short_nxt;
    logic              short_done;
    logic              hw_clr;
    logic              armed;
    bod_state_e        state_q;

    assign hw_clr = dma_tc || short_done;
    assign armed  = en_q && (mode_q == MODE_W'(MODE_DEMAND)) && !short_sts_q;

    bod_fifo_cnt #(.DEPTH(DEPTH)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_ok       (pkt_ok),
        .pkt_len      (pkt_len),
        .fifo_rd      (fifo_rd),
        .cnt_q        (cnt_q),
        .cnt_zero_nxt (cnt_zero_nxt),
        .pkt_accept   (pkt_accept),
        .last_rd      (last_rd),
        .pkt_short_q  (pkt_short_q),
        .underflow_q  (underflow)
    );

    bod_cfg_reg #(.MODE_W(MODE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_en   (cfg_en),
        .cfg_mode (cfg_mode),
        .hw_clr   (hw_clr),
        .en_q     (en_q),
        .mode_q   (mode_q),
        .en_nxt   (en_nxt),
        .mode_nxt (mode_nxt)
    );

    bod_status u_sts (
        .clk           (clk),
        .rst_n         (rst_n),
        .short_done    (short_done),
        .short_clr     (short_clr),
        .dma_tc        (dma_tc),
        .pkt_accept    (pkt_accept),
        .armed         (armed),
        .short_sts_q   (short_sts_q),
        .short_nxt     (short_nxt),
        .rx_irq_q      (rx_irq),
        .short_irq_q   (short_irq),
        .ep_end_irq_q  (ep_end_irq),
        .dma_end_irq_q (dma_end_irq)
    );

    bod_req_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_zero_nxt (cnt_zero_nxt),
        .en_nxt       (en_nxt),
        .mode_nxt     (mode_nxt),
        .short_nxt    (short_nxt),
        .last_rd      (last_rd),
        .pkt_short_q  (pkt_short_q),
        .en_q         (en_q),
        .mode_q       (mode_q),
        .cnt_nz       (cnt_q != '0),
        .short_sts_q  (short_sts_q),
        .state_q      (state_q),
        .dma_req      (dma_req),
        .short_done   (short_done)
    );

    assign dma_stop = short_sts_q;
    assign dma_en   = en_q;
    assign byte_cnt = cnt_q;

    // R2: never a request while the enable output is low.
    p_no_req_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    // R7: the stop output and the request are exclusive.
    p_stop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_stop && dma_req));

endmodule

// File: tb/bulk_out_dma_req_test.sv
module bulk_out_dma_req_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr, cfg_en;
    logic [1:0] cfg_mode;
    logic       pkt_ok;
    logic [6:0] pkt_len;
    logic       fifo_rd, dma_tc, short_clr;
    logic       dma_req, rx_irq, short_irq, ep_end_irq, dma_end_irq;
    logic       dma_stop, dma_en, underflow;
    logic [6:0] byte_cnt;

    int total = 0;
    int bad   = 0;
    bit req_while_off = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bulk_out_dma_req uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_mode(cfg_mode), .pkt_ok(pkt_ok), .pkt_len(pkt_len),
        .fifo_rd(fifo_rd), .dma_tc(dma_tc), .short_clr(short_clr),
        .dma_req(dma_req), .rx_irq(rx_irq), .short_irq(short_irq),
        .ep_end_irq(ep_end_irq), .dma_end_irq(dma_end_irq),
        .dma_stop(dma_stop), .dma_en(dma_en), .byte_cnt(byte_cnt),
        .underflow(underflow)
    );

    // R2 monitor: the request must never be high with the enable bit low.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dma_req === 1'b1 && dma_en !== 1'b1) req_while_off = 1'b1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic en, input logic [1:0] mode);
        cfg_wr = 1'b1; cfg_en = en; cfg_mode = mode;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic send_pkt(input int n);
        pkt_ok = 1'b1; pkt_len = 7'(n);
        tick();
        pkt_ok = 1'b0;
    endtask

    task automatic read_bytes(input int n);
        fifo_rd = 1'b1;
        for (int i = 0; i < n; i++) tick();
        fifo_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "dma_req", dma_req, 0);
        chk("R1", "dma_en", dma_en, 0);
        chk("R1", "byte_cnt", byte_cnt, 0);
        chk("R1", "dma_stop", dma_stop, 0);
        chk("R1", "irqs", {rx_irq, short_irq, ep_end_irq, dma_end_irq}, 0);
        chk("R1", "underflow", underflow, 0);
    endtask

    task automatic t_no_dma();
        send_pkt(10);
        chk("R3", "rx_irq pulse when disarmed", rx_irq, 1);
        chk("R2", "no req while disabled", dma_req, 0);
        chk("R9", "count loaded", byte_cnt, 10);
        tick();
        chk("R3", "rx_irq one cycle", rx_irq, 0);
        read_bytes(4);
        chk("R9", "count after 4 reads", byte_cnt, 6);
        read_bytes(6);
        chk("R9", "count drained", byte_cnt, 0);
        chk("R2", "still no req", dma_req, 0);
    endtask

    task automatic t_full_pkt();
        write_cfg(1'b1, 2'b10);
        send_pkt(64);
        chk("R4", "req after packet", dma_req, 1);
        chk("R3", "rx_irq suppressed when armed", rx_irq, 0);
        read_bytes(63);
        chk("R4", "req held with 1 byte left", dma_req, 1);
        chk("R9", "one byte left", byte_cnt, 1);
        read_bytes(1);
        chk("R4", "req low after last read", dma_req, 0);
        chk("R5", "no short irq on 64 bytes", short_irq, 0);
        chk("R5", "no ep_end irq on 64 bytes", ep_end_irq, 0);
        chk("R5", "enable kept on 64 bytes", dma_en, 1);
        send_pkt(64);
        chk("R4", "req reasserts on next packet", dma_req, 1);
        read_bytes(64);
        chk("R4", "req low after second drain", dma_req, 0);
    endtask

    task automatic t_short_pkt();
        send_pkt(20);
        chk("R4", "req for short packet", dma_req, 1);
        read_bytes(19);
        chk("R4", "req held before last", dma_req, 1);
        read_bytes(1);
        chk("R5", "short_irq", short_irq, 1);
        chk("R5", "ep_end_irq", ep_end_irq, 1);
        chk("R5", "req low", dma_req, 0);
        chk("R5", "enable cleared", dma_en, 0);
        chk("R5", "dma_stop high", dma_stop, 1);
        tick();
        chk("R5", "short_irq one cycle", short_irq, 0);
        chk("R5", "ep_end_irq one cycle", ep_end_irq, 0);
    endtask

    task automatic t_stop_block();
        write_cfg(1'b1, 2'b10);
        send_pkt(5);
        chk("R7", "req blocked by stop", dma_req, 0);
        chk("R3", "rx_irq while blocked", rx_irq, 1);
        tick();
        chk("R7", "still blocked", dma_req, 0);
        chk("R7", "stop held", dma_stop, 1);
        short_clr = 1'b1;
        tick();
        short_clr = 1'b0;
        chk("R7", "stop cleared", dma_stop, 0);
        chk("R7", "req resumes after clear", dma_req, 1);
        read_bytes(5);
        chk("R5", "short again on 5 bytes", short_irq, 1);
        chk("R7", "stop set again", dma_stop, 1);
        short_clr = 1'b1;
        tick();
        short_clr = 1'b0;
        chk("R7", "stop cleared again", dma_stop, 0);
    endtask

    task automatic t_tc();
        write_cfg(1'b1, 2'b10);
        send_pkt(40);
        read_bytes(10);
        chk("R6", "req before tc", dma_req, 1);
        dma_tc = 1'b1;
        tick();
        dma_tc = 1'b0;
        chk("R6", "req low after tc", dma_req, 0);
        chk("R6", "enable cleared by tc", dma_en, 0);
        chk("R6", "dma_end_irq", dma_end_irq, 1);
        chk("R6", "bytes kept", byte_cnt, 30);
        tick();
        chk("R6", "dma_end_irq one cycle", dma_end_irq, 0);
        chk("R6", "no self restart", dma_req, 0);
        write_cfg(1'b1, 2'b10);
        chk("R6", "req after re-enable", dma_req, 1);
        read_bytes(30);
        chk("R5", "short at end of resumed packet", short_irq, 1);
        short_clr = 1'b1;
        tick();
        short_clr = 1'b0;
    endtask

    task automatic t_mode();
        write_cfg(1'b1, 2'b01);
        send_pkt(64);
        chk("R8", "no req in mode 01", dma_req, 0);
        chk("R3", "rx_irq in mode 01", rx_irq, 1);
        write_cfg(1'b1, 2'b11);
        chk("R8", "no req in mode 11", dma_req, 0);
        write_cfg(1'b1, 2'b10);
        chk("R8", "req after demand mode", dma_req, 1);
        read_bytes(64);
        chk("R8", "req low after drain", dma_req, 0);
    endtask

    task automatic t_underflow();
        chk("R9", "underflow clear before", underflow, 0);
        read_bytes(1);
        chk("R9", "count stays 0", byte_cnt, 0);
        chk("R9", "underflow set", underflow, 1);
        tick();
        tick();
        chk("R9", "underflow sticky", underflow, 1);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0; cfg_mode = 2'b00;
        pkt_ok = 1'b0; pkt_len = '0; fifo_rd = 1'b0; dma_tc = 1'b0; short_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_no_dma();
        t_full_pkt();
        t_short_pkt();
        t_stop_block();
        t_tc();
        t_mode();
        t_underflow();
        chk("R2", "req never high while disabled", int'(req_while_off), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule